// File: doc/BRIEF.md
# Thread-Block Admission Gate

The gate keeps a running account of how much of one processing core is already taken by resident thread blocks: thread slots, shared-memory bytes, registers and block count. For any requested block it answers, in the same cycle, whether one more block of that shape fits alongside the ones already running. The answer can come from different kernels sharing the core. A caller can ask without committing (probe), commit (claim), or hand the resources of a finished block back (release). The core's limits and the warp width are elaboration parameters.

Before it compares, the gate pads the block's thread count up to a whole number of warps. It rounds the per-thread register count up to a multiple of four and takes the register demand as the product of the two. All limits are checked at once. A claim commits only when the answer is yes. A release must present the same block shape that was claimed. A release that would drive any account below zero is refused and flagged. When sharing between kernels is switched off, the gate falls back to a plain block-count limit supplied per kernel.

Top module: `blk_admit`

## Requirements
- R1: After reset all four occupancy counters read zero and `relError` is low.
- R2: The thread amount used in checks and bookkeeping is `threadsPerBlk` rounded up to the next multiple of `WARP_SIZE` (33 threads with a 32-wide warp count as 64).
- R3: Register demand is the padded thread count times `regsPerThread` rounded up to a multiple of four (37 and 40 registers per thread give equal demand).
- R4: In shared mode, `fit` is low when occupied plus requested threads, shared memory or registers would exceed `MAX_THREADS`, `MAX_SHMEM` or `MAX_REGS`, or when one more block would exceed `MAX_BLOCKS`. A request that lands exactly on every limit fits.
- R5: In shared mode, `fit` is low when `slotFree` is low or `kernMaxBlk` is zero.
- R6: `op` = 2'b01 (claim) with `fit` high adds the padded threads, shared memory, registers and one block to the counters at the next clock edge. A claim with `fit` low changes no counter.
- R7: `op` = 2'b11 (probe) and `op` = 2'b00 (idle) leave every counter unchanged, while `fit` still reflects the presented request.
- R8: `op` = 2'b10 (release) subtracts the same amounts a claim of that request would add. If any counter holds less than its amount, no counter changes and `relError` is high for the cycle after that edge.
- R9: With `shareMode` low, `fit` is high exactly when `occBlocks` is below both `kernMaxBlk` and `MAX_BLOCKS`. Thread, register, shared-memory and slot inputs are ignored, and claim or release changes only `occBlocks` (release refused with `relError` when it is zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| shareMode | input | 1 | 1: several kernels share the core (full resource check); 0: block-count check only |
| op | input | 2 | 00 idle, 01 claim, 10 release, 11 probe |
| threadsPerBlk | input | $clog2(MAX_THREADS+1) | Threads in the requested block |
| regsPerThread | input | REG_PT_W | Registers per thread |
| shmemPerBlk | input | $clog2(MAX_SHMEM+1) | Shared-memory bytes per block |
| slotFree | input | 1 | An aligned free run of thread slots exists |
| kernMaxBlk | input | $clog2(MAX_BLOCKS+1) | Kernel's maximum resident blocks per core |
| fit | output | 1 | Request fits now (combinational) |
| relError | output | 1 | Previous cycle's release was refused |
| occThreads | output | $clog2(MAX_THREADS+1) | Occupied thread slots |
| occShmem | output | $clog2(MAX_SHMEM+1) | Occupied shared-memory bytes |
| occRegs | output | $clog2(MAX_REGS+1) | Occupied registers |
| occBlocks | output | $clog2(MAX_BLOCKS+1) | Resident blocks |

## Verification
The bench builds the gate with a 32-wide warp, 256 thread slots, 1024 bytes of shared memory, 4096 registers and 4 blocks. With these limits each account can be filled to exactly its limit within a few claims, so the exact-limit and one-over cases of every resource, the register rounding and the block cap all come up in a short vector walk. The small block counter also lets the non-shared mode reach both of its bounds, and a refused release can be provoked right after reset.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'b00,
    OP_CLAIM   = 2'b01,
    OP_RELEASE = 2'b10,
    OP_PROBE   = 2'b11
  } admit_op_e;

  typedef struct packed {
    logic add;
    logic sub;
  } admit_stb_t;

endpackage

// File: rtl/blk_admit_ctrl.sv
module blk_admit_ctrl
  import blk_admit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] op,
  input  logic       fit,
  input  logic       shortfall,
  output admit_stb_t stb,
  output logic       relError
);

  admit_op_e opCode;
  assign opCode = admit_op_e'(op);

  always_comb begin
    stb.add = (opCode == OP_CLAIM) && fit;
    stb.sub = (opCode == OP_RELEASE) && !shortfall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) relError <= 1'b0;
    else       relError <= (opCode == OP_RELEASE) && shortfall;
  end

endmodule

// File: rtl/blk_admit_dp.sv
module blk_admit_dp
  import blk_admit_pkg::*;
#(
  parameter int WARP_SIZE   = 32,
  parameter int MAX_THREADS = 2048,
  parameter int MAX_SHMEM   = 49152,
  parameter int MAX_REGS    = 65536,
  parameter int MAX_BLOCKS  = 32,
  parameter int REG_PT_W    = 8,
  localparam int THR_W = $clog2(MAX_THREADS + 1),
  localparam int SHM_W = $clog2(MAX_SHMEM + 1),
  localparam int REG_W = $clog2(MAX_REGS + 1),
  localparam int BLK_W = $clog2(MAX_BLOCKS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                shareMode,
  input  logic [THR_W-1:0]    threadsPerBlk,
  input  logic [REG_PT_W-1:0] regsPerThread,
  input  logic [SHM_W-1:0]    shmemPerBlk,
  input  logic                slotFree,
  input  logic [BLK_W-1:0]    kernMaxBlk,
  input  admit_stb_t          stb,
  output logic                fit,
  output logic                shortfall,
  output logic [THR_W-1:0]    occThreads,
  output logic [SHM_W-1:0]    occShmem,
  output logic [REG_W-1:0]    occRegs,
  output logic [BLK_W-1:0]    occBlocks
);

  localparam logic [31:0] WMASK   = 32'(WARP_SIZE - 1);
  localparam logic [31:0] LIM_THR = 32'(MAX_THREADS);
  localparam logic [31:0] LIM_SHM = 32'(MAX_SHMEM);
  localparam logic [31:0] LIM_REG = 32'(MAX_REGS);
  localparam logic [31:0] LIM_BLK = 32'(MAX_BLOCKS);

  logic [31:0] padThr, regRnd, regNeed, shmNeed;
  logic thrOk, shmOk, regOk, blkOk, fitShared, fitSolo;
  logic shortShared, shortSolo;

  // demand of one block: warp-padded threads, four-aligned registers
  always_comb begin
    padThr  = (32'(threadsPerBlk) + WMASK) & ~WMASK;
    regRnd  = (32'(regsPerThread) + 32'd3) & ~32'd3;
    regNeed = padThr * regRnd;
    shmNeed = 32'(shmemPerBlk);
  end

  always_comb begin
    thrOk = (32'(occThreads) + padThr)  <= LIM_THR;
    shmOk = (32'(occShmem)   + shmNeed) <= LIM_SHM;
    regOk = (32'(occRegs)    + regNeed) <= LIM_REG;
    blkOk = (32'(occBlocks)  + 32'd1)   <= LIM_BLK;
    fitShared = (kernMaxBlk != '0) && slotFree && thrOk && shmOk && regOk && blkOk;
    fitSolo   = (32'(occBlocks) < 32'(kernMaxBlk)) && (32'(occBlocks) < LIM_BLK);
    fit       = shareMode ? fitShared : fitSolo;
    shortShared = (32'(occThreads) < padThr) || (32'(occShmem) < shmNeed) ||
                  (32'(occRegs) < regNeed)   || (occBlocks == '0);
    shortSolo   = (occBlocks == '0);
    shortfall   = shareMode ? shortShared : shortSolo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occThreads <= '0;
      occShmem   <= '0;
      occRegs    <= '0;
      occBlocks  <= '0;
    end else if (stb.add) begin
      occBlocks <= occBlocks + BLK_W'(1);
      if (shareMode) begin
        occThreads <= occThreads + THR_W'(padThr);
        occShmem   <= occShmem   + SHM_W'(shmNeed);
        occRegs    <= occRegs    + REG_W'(regNeed);
      end
    end else if (stb.sub) begin
      occBlocks <= occBlocks - BLK_W'(1);
      if (shareMode) begin
        occThreads <= occThreads - THR_W'(padThr);
        occShmem   <= occShmem   - SHM_W'(shmNeed);
        occRegs    <= occRegs    - REG_W'(regNeed);
      end
    end
  end

  // R4: accounts never pass their limits
  p_thr_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    32'(occThreads) <= LIM_THR);
  p_shm_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    32'(occShmem) <= LIM_SHM);
  p_reg_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    32'(occRegs) <= LIM_REG);
  p_blk_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    32'(occBlocks) <= LIM_BLK);
  // R6: control commits a claim only on a yes answer
  p_claim_fits_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.add |-> fit);
  // R8: control subtracts only when every account covers the amount
  p_release_covered_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.sub |-> !shortfall);
  // R7: without a strobe nothing moves
  p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.add && !stb.sub) |=> ($stable(occThreads) && $stable(occShmem) &&
                                $stable(occRegs) && $stable(occBlocks)));

endmodule

// File: rtl/blk_admit.sv
module blk_admit
  import blk_admit_pkg::*;
#(
  parameter int WARP_SIZE   = 32,
  parameter int MAX_THREADS = 2048,
  parameter int MAX_SHMEM   = 49152,
  parameter int MAX_REGS    = 65536,
  parameter int MAX_BLOCKS  = 32,
  parameter int REG_PT_W    = 8,
  localparam int THR_W = $clog2(MAX_THREADS + 1),
  localparam int SHM_W = $clog2(MAX_SHMEM + 1),
  localparam int REG_W = $clog2(MAX_REGS + 1),
  localparam int BLK_W = $clog2(MAX_BLOCKS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                shareMode,
  input  logic [1:0]          op,
  input  logic [THR_W-1:0]    threadsPerBlk,
  input  logic [REG_PT_W-1:0] regsPerThread,
  input  logic [SHM_W-1:0]    shmemPerBlk,
  input  logic                slotFree,
  input  logic [BLK_W-1:0]    kernMaxBlk,
  output logic                fit,
  output logic                relError,
  output logic [THR_W-1:0]    occThreads,
  output logic [SHM_W-1:0]    occShmem,
  output logic [REG_W-1:0]    occRegs,
  output logic [BLK_W-1:0]    occBlocks
);

  admit_stb_t stb;
  logic       shortfall;

  blk_admit_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .op        (op),
    .fit       (fit),
    .shortfall (shortfall),
    .stb       (stb),
    .relError  (relError)
  );

  blk_admit_dp #(
    .WARP_SIZE   (WARP_SIZE),
    .MAX_THREADS (MAX_THREADS),
    .MAX_SHMEM   (MAX_SHMEM),
    .MAX_REGS    (MAX_REGS),
    .MAX_BLOCKS  (MAX_BLOCKS),
    .REG_PT_W    (REG_PT_W)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .shareMode     (shareMode),
    .threadsPerBlk (threadsPerBlk),
    .regsPerThread (regsPerThread),
    .shmemPerBlk   (shmemPerBlk),
    .slotFree      (slotFree),
    .kernMaxBlk    (kernMaxBlk),
    .stb           (stb),
    .fit           (fit),
    .shortfall     (shortfall),
    .occThreads    (occThreads),
    .occShmem      (occShmem),
    .occRegs       (occRegs),
    .occBlocks     (occBlocks)
  );

endmodule

// File: tb/blk_admit_tb_top.sv
`timescale 1ns/1ps
module blk_admit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        shareMode = 1'b1;
  logic [1:0]  op = 2'b00;
  logic [8:0]  threadsPerBlk = '0;
  logic [7:0]  regsPerThread = '0;
  logic [10:0] shmemPerBlk = '0;
  logic        slotFree = 1'b0;
  logic [2:0]  kernMaxBlk = '0;
  logic        fit, relError;
  logic [8:0]  occThreads;
  logic [10:0] occShmem;
  logic [12:0] occRegs;
  logic [2:0]  occBlocks;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  blk_admit #(
    .WARP_SIZE(32), .MAX_THREADS(256), .MAX_SHMEM(1024),
    .MAX_REGS(4096), .MAX_BLOCKS(4), .REG_PT_W(8)
  ) dut_i (
    .clk(clk), .rstN(rstN), .shareMode(shareMode), .op(op),
    .threadsPerBlk(threadsPerBlk), .regsPerThread(regsPerThread),
    .shmemPerBlk(shmemPerBlk), .slotFree(slotFree), .kernMaxBlk(kernMaxBlk),
    .fit(fit), .relError(relError), .occThreads(occThreads),
    .occShmem(occShmem), .occRegs(occRegs), .occBlocks(occBlocks)
  );

  typedef struct packed {
    bit        mode;
    bit [1:0]  op;
    bit [8:0]  tpb;
    bit [7:0]  rpt;
    bit [10:0] shm;
    bit        slot;
    bit [2:0]  mb;
    bit        eFit;
    bit        eErr;
    bit [8:0]  eThr;
    bit [10:0] eShm;
    bit [12:0] eReg;
    bit [2:0]  eBlk;
  } vec_t;

  localparam int NV = 25;
  // mode, op, threads, regs, shmem, slot, kernMax | fit, err, thr, shm, reg, blk
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd3,  9'd33,  8'd5, 11'd100, 1'b1, 3'd4, 1'b1, 1'b0,   9'd0,    11'd0,    13'd0, 3'd0}, // R2 probe
    '{1'b1, 2'd1,  9'd33,  8'd5, 11'd100, 1'b1, 3'd4, 1'b1, 1'b0,  9'd64,  11'd100,  13'd512, 3'd1}, // R2 R3 R6
    '{1'b1, 2'd1,  9'd64, 8'd16, 11'd200, 1'b1, 3'd4, 1'b1, 1'b0, 9'd128,  11'd300, 13'd1536, 3'd2}, // R6
    '{1'b1, 2'd3, 9'd129,  8'd1,   11'd0, 1'b1, 3'd4, 1'b0, 1'b0, 9'd128,  11'd300, 13'd1536, 3'd2}, // R4 threads
    '{1'b1, 2'd1, 9'd128, 8'd20,   11'd0, 1'b1, 3'd4, 1'b1, 1'b0, 9'd256,  11'd300, 13'd4096, 3'd3}, // R4 exact
    '{1'b1, 2'd3,   9'd1,  8'd1,   11'd0, 1'b1, 3'd4, 1'b0, 1'b0, 9'd256,  11'd300, 13'd4096, 3'd3}, // R4 R2
    '{1'b1, 2'd2, 9'd128, 8'd20,   11'd0, 1'b1, 3'd4, 1'b0, 1'b0, 9'd128,  11'd300, 13'd1536, 3'd2}, // R8
    '{1'b1, 2'd1,  9'd32,  8'd1, 11'd724, 1'b1, 3'd4, 1'b1, 1'b0, 9'd160, 11'd1024, 13'd1664, 3'd3}, // R4 shm exact
    '{1'b1, 2'd3,  9'd32,  8'd1,   11'd1, 1'b1, 3'd4, 1'b0, 1'b0, 9'd160, 11'd1024, 13'd1664, 3'd3}, // R4 shm
    '{1'b1, 2'd3,  9'd32,  8'd1,   11'd0, 1'b0, 3'd4, 1'b0, 1'b0, 9'd160, 11'd1024, 13'd1664, 3'd3}, // R5 slot
    '{1'b1, 2'd3,  9'd32,  8'd1,   11'd0, 1'b1, 3'd0, 1'b0, 1'b0, 9'd160, 11'd1024, 13'd1664, 3'd3}, // R5 kmax
    '{1'b1, 2'd3,  9'd32,  8'd1,   11'd0, 1'b1, 3'd4, 1'b1, 1'b0, 9'd160, 11'd1024, 13'd1664, 3'd3}, // R7
    '{1'b1, 2'd1,  9'd32,  8'd1,   11'd0, 1'b1, 3'd4, 1'b1, 1'b0, 9'd192, 11'd1024, 13'd1792, 3'd4}, // R6
    '{1'b1, 2'd3,  9'd32,  8'd1,   11'd0, 1'b1, 3'd4, 1'b0, 1'b0, 9'd192, 11'd1024, 13'd1792, 3'd4}, // R4 blocks
    '{1'b1, 2'd2,  9'd32,  8'd1, 11'd724, 1'b1, 3'd4, 1'b0, 1'b0, 9'd160,  11'd300, 13'd1664, 3'd3}, // R8
    '{1'b1, 2'd3,  9'd64, 8'd40,   11'd0, 1'b1, 3'd4, 1'b0, 1'b0, 9'd160,  11'd300, 13'd1664, 3'd3}, // R4 regs
    '{1'b1, 2'd3,  9'd64, 8'd37,   11'd0, 1'b1, 3'd4, 1'b0, 1'b0, 9'd160,  11'd300, 13'd1664, 3'd3}, // R3 round
    '{1'b1, 2'd3,  9'd64, 8'd36,   11'd0, 1'b1, 3'd4, 1'b1, 1'b0, 9'd160,  11'd300, 13'd1664, 3'd3}, // R3
    '{1'b0, 2'd3, 9'd200, 8'd200, 11'd1000, 1'b0, 3'd4, 1'b1, 1'b0, 9'd160, 11'd300, 13'd1664, 3'd3}, // R9
    '{1'b0, 2'd1, 9'd200, 8'd200, 11'd1000, 1'b0, 3'd4, 1'b1, 1'b0, 9'd160, 11'd300, 13'd1664, 3'd4}, // R9
    '{1'b0, 2'd3, 9'd200, 8'd200, 11'd1000, 1'b0, 3'd4, 1'b0, 1'b0, 9'd160, 11'd300, 13'd1664, 3'd4}, // R9
    '{1'b0, 2'd2, 9'd200, 8'd200, 11'd1000, 1'b0, 3'd4, 1'b0, 1'b0, 9'd160, 11'd300, 13'd1664, 3'd3}, // R9
    '{1'b1, 2'd1, 9'd256,  8'd1,   11'd0, 1'b1, 3'd4, 1'b0, 1'b0, 9'd160,  11'd300, 13'd1664, 3'd3}, // R6 no-fit
    '{1'b1, 2'd2, 9'd256,  8'd1,   11'd0, 1'b1, 3'd4, 1'b0, 1'b1, 9'd160,  11'd300, 13'd1664, 3'd3}, // R8 refuse
    '{1'b1, 2'd3,  9'd32,  8'd1,   11'd0, 1'b1, 3'd4, 1'b1, 1'b0, 9'd160,  11'd300, 13'd1664, 3'd3}  // R8 pulse
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkState(input string tag, input int t, input int s, input int r, input int b);
    check(occThreads == 9'(t), {tag, " threads"}, int'(occThreads), t);
    check(occShmem == 11'(s),  {tag, " shmem"},   int'(occShmem), s);
    check(occRegs == 13'(r),   {tag, " regs"},    int'(occRegs), r);
    check(occBlocks == 3'(b),  {tag, " blocks"},  int'(occBlocks), b);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checkState("R1 reset", 0, 0, 0, 0);
    check(relError == 1'b0, "R1 relError", int'(relError), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      shareMode     = VECS[i].mode;
      op            = VECS[i].op;
      threadsPerBlk = VECS[i].tpb;
      regsPerThread = VECS[i].rpt;
      shmemPerBlk   = VECS[i].shm;
      slotFree      = VECS[i].slot;
      kernMaxBlk    = VECS[i].mb;
      #1;
      check(fit == VECS[i].eFit, $sformatf("R4/R5/R9 fit vec %0d", i), int'(fit), int'(VECS[i].eFit));
      @(negedge clk);
      check(relError == VECS[i].eErr, $sformatf("R8 relError vec %0d", i), int'(relError), int'(VECS[i].eErr));
      checkState($sformatf("R6/R7/R8 vec %0d", i), int'(VECS[i].eThr), int'(VECS[i].eShm),
                 int'(VECS[i].eReg), int'(VECS[i].eBlk));
    end

    // R7: idle op leaves state alone
    op = 2'b00;
    @(negedge clk);
    checkState("R7 idle", 160, 300, 1664, 3);

    // R1: reset in mid-run clears everything
    rstN = 1'b0;
    @(negedge clk);
    checkState("R1 mid reset", 0, 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R9: release with no resident block in non-shared mode is refused
    shareMode = 1'b0;
    op = 2'b10;
    @(negedge clk);
    check(relError == 1'b1, "R9 empty release", int'(relError), 1);
    checkState("R9 empty release", 0, 0, 0, 0);
    op = 2'b00;
    @(negedge clk);
    check(relError == 1'b0, "R8 pulse clears", int'(relError), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule